// File: doc/BRIEF.md
# Vector Tree Reduction Unit

This unit adds up an arbitrarily long stream of integers by spreading the work over a register of `VL` parallel partial sums and then folding those partial sums together in a halving tree. The stream arrives in chunks of up to `VL` elements per transfer over a valid/ready handshake. Element `j` of every chunk is added into partial sum `j`, so the loop-carried dependency of a serial sum is broken into `VL` independent accumulators. A chunk may carry fewer than `VL` live elements. The unused lanes add nothing, so a remainder strip (for example N mod `VL` elements sent ahead of the full strips) needs no special treatment.

When the chunk flagged as last has been taken, input is held off. The unit then halves the active length once per cycle. In each of those steps it adds the upper half of the live partial sums onto the lower half, and after log2(`VL`) steps partial sum 0 holds the total. The total is shown for one cycle with a valid strobe. The partial sums are then cleared and the unit accepts the next stream. All arithmetic wraps modulo 2^`W`.

Top module: `vec_tree_sum`

## Requirements
- R1: After reset `outValid` is low, `inReady` is high and every partial sum is zero.
- R2: A chunk is taken on a rising edge where `inValid` and `inReady` are both high. `inReady` is high only while the unit is accumulating. It is low from the edge that takes a last chunk until the reduction has finished.
- R3: Lane `j` of a chunk sits at `inData[j*W +: W]`. It is added into partial sum `j` when `j < inCount`. `inCount` ranges from 0 to `VL`.
- R4: Lanes at or above `inCount` contribute zero, whatever their data.
- R5: A chunk with `inLast` high ends the stream. The halving tree then runs for log2(`VL`) cycles. `outValid` is high only in the clock cycle that begins at the log2(`VL`)-th rising edge after the edge that took the last chunk, and it is high for that single cycle.
- R6: While `outValid` is high, `outSum` equals the sum modulo 2^`W` of every element taken since the previous result, or since reset.
- R7: A stream that consists of one last chunk with `inCount` = 0 gives `outSum` = 0.
- R8: In the cycle after `outValid`, `inReady` is high again and the partial sums are zero. The next result depends only on chunks taken after that point.
- R9: `inValid`, `inData`, `inCount` and `inLast` have no effect while `inReady` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A chunk is presented |
| inReady | output | 1 | The unit takes a chunk this cycle |
| inData | input | VL*W | Chunk elements; lane j at bits j*W upward |
| inCount | input | $clog2(VL)+1 | Number of live lanes, counted from lane 0 |
| inLast | input | 1 | This chunk ends the stream |
| outValid | output | 1 | One-cycle strobe: `outSum` holds the result |
| outSum | output | W | Reduced total, modulo 2^W |

## Verification
The condition hardest to reach from the ports is a sender that keeps offering chunks while the tree is folding. Such a chunk could only corrupt a result if the unit wrongly accepted it. The stimulus creates this by keeping `inValid` high with a last flag and junk lanes through the whole tree phase. It drops the request only in the cycle that shows the result, then checks both that total and the following stream. Stream lengths of zero, one, just below, equal to and just above a multiple of `VL` exercise the short-remainder masking and the wrapping total. Junk data is placed in every masked lane.

// File: rtl/vec_tree_sum_pkg.sv
package vec_tree_sum_pkg;

  localparam int MAX_LEVEL_W = 3;

  typedef enum logic [1:0] {
    ST_ACCUM = 2'd0,
    ST_TREE  = 2'd1,
    ST_DONE  = 2'd2
  } phase_t;

  typedef struct packed {
    logic                   clearAcc;
    logic                   accumEn;
    logic                   treeEn;
    logic [MAX_LEVEL_W-1:0] level;
  } strobes_t;

endpackage

// File: rtl/vec_tree_sum_ctrl.sv
module vec_tree_sum_ctrl
  import vec_tree_sum_pkg::*;
#(
  parameter int VL = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     inValid,
  input  logic     inLast,
  output logic     inReady,
  output logic     outValid,
  output strobes_t strobes
);

  localparam int LEVELS = $clog2(VL);
  localparam logic [MAX_LEVEL_W-1:0] LAST_LEVEL = MAX_LEVEL_W'(LEVELS - 1);

  phase_t phase, phaseNext;
  logic [MAX_LEVEL_W-1:0] level, levelNext;

  always_comb begin
    phaseNext       = phase;
    levelNext       = level;
    strobes         = '0;
    strobes.level   = level;
    inReady         = 1'b0;
    outValid        = 1'b0;
    unique case (phase)
      ST_ACCUM: begin
        inReady = 1'b1;
        if (inValid) begin
          strobes.accumEn = 1'b1;
          if (inLast) begin
            phaseNext = ST_TREE;
            levelNext = '0;
          end
        end
      end
      ST_TREE: begin
        strobes.treeEn = 1'b1;
        if (level == LAST_LEVEL) begin
          phaseNext = ST_DONE;
          levelNext = '0;
        end else begin
          levelNext = level + 1'b1;
        end
      end
      ST_DONE: begin
        outValid         = 1'b1;
        strobes.clearAcc = 1'b1;
        phaseNext        = ST_ACCUM;
      end
      default: phaseNext = ST_ACCUM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= ST_ACCUM;
      level <= '0;
    end else begin
      phase <= phaseNext;
      level <= levelNext;
    end
  end

endmodule

// File: rtl/vec_tree_sum_datapath.sv
module vec_tree_sum_datapath
  import vec_tree_sum_pkg::*;
#(
  parameter int VL = 8,
  parameter int W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  strobes_t               strobes,
  input  logic [VL*W-1:0]        inData,
  input  logic [$clog2(VL):0]    inCount,
  output logic [W-1:0]           outSum
);

  localparam int LEVELS = $clog2(VL);
  localparam int CNT_W  = $clog2(VL) + 1;

  logic [W-1:0] acc     [VL];
  logic [W-1:0] accNext [VL];

  for (genvar j = 0; j < VL; j++) begin : g_lane
    logic [W-1:0] laneIn;
    logic [W-1:0] partner;

    // Lanes at or beyond the live count feed zero into the sum.
    assign laneIn = (CNT_W'(j) < inCount) ? inData[j*W +: W] : '0;

    // Pick the upper-half element folded onto this lane at the current level.
    always_comb begin
      partner = '0;
      for (int s = 0; s < LEVELS; s++) begin
        if ((int'(strobes.level) == s) && (j < (VL >> (s + 1))))
          partner = acc[(j + (VL >> (s + 1))) & (VL - 1)];
      end
    end

    always_comb begin
      accNext[j] = acc[j];
      if (strobes.clearAcc)
        accNext[j] = '0;
      else if (strobes.accumEn)
        accNext[j] = acc[j] + laneIn;
      else if (strobes.treeEn)
        accNext[j] = acc[j] + partner;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc[j] <= '0;
      else        acc[j] <= accNext[j];
    end
  end

  assign outSum = acc[0];

endmodule

// File: rtl/vec_tree_sum.sv
module vec_tree_sum
  import vec_tree_sum_pkg::*;
#(
  parameter int VL = 8,
  parameter int W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  output logic                inReady,
  input  logic [VL*W-1:0]     inData,
  input  logic [$clog2(VL):0] inCount,
  input  logic                inLast,
  output logic                outValid,
  output logic [W-1:0]        outSum
);

  strobes_t strobes;

  vec_tree_sum_ctrl #(.VL(VL)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inLast   (inLast),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  vec_tree_sum_datapath #(.VL(VL), .W(W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .inData  (inData),
    .inCount (inCount),
    .outSum  (outSum)
  );

endmodule

// File: rtl/vec_tree_sum_chk.sv
module vec_tree_sum_chk #(
  parameter int VL = 8,
  parameter int W  = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         inValid,
  input logic         inReady,
  input logic         inLast,
  input logic         outValid,
  input logic [W-1:0] outSum
);

  localparam int LEVELS = $clog2(VL);
  localparam int CW     = $clog2(LEVELS + 2) + 1;

  logic [CW-1:0] since;
  logic          seenResult;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since      <= '0;
      seenResult <= 1'b0;
    end else begin
      if (inValid && inReady && inLast)            since <= CW'(1);
      else if (since != 0 && since <= CW'(LEVELS)) since <= since + 1'b1;
      else                                         since <= '0;
      if (outValid) seenResult <= 1'b1;
    end
  end

  AST_READY_LOW_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !inReady);                                          // R2
  AST_HOLD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady && inLast) |=> !inReady);                    // R2
  AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    outValid == (since == CW'(LEVELS + 1)));                         // R5
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |=> !outValid);                                         // R5
  AST_READY_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |=> inReady);                                           // R8
  AST_NO_RESULT_BEFORE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (!seenResult && since == 0) |-> !outValid);                      // R1

endmodule

bind vec_tree_sum vec_tree_sum_chk #(.VL(VL), .W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .inReady  (inReady),
  .inLast   (inLast),
  .outValid (outValid),
  .outSum   (outSum)
);

// File: tb/vec_tree_sum_bench.sv
module vec_tree_sum_bench;

  localparam int VL     = 8;
  localparam int W      = 16;
  localparam int LEVELS = $clog2(VL);
  localparam int NCASE  = 10;
  localparam int CASE_N    [NCASE] = '{0, 1, 7, 8, 9, 16, 23, 64, 100, 200};
  localparam int CASE_SEED [NCASE] = '{3, 5, 11, 13, 17, 19, 23, 29, 31, 37};

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                inValid = 1'b0;
  logic                inReady;
  logic [VL*W-1:0]     inData = '0;
  logic [$clog2(VL):0] inCount = '0;
  logic                inLast = 1'b0;
  logic                outValid;
  logic [W-1:0]        outSum;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vec_tree_sum #(.VL(VL), .W(W)) u_vec_tree_sum (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inCount(inCount), .inLast(inLast),
    .outValid(outValid), .outSum(outSum)
  );

  function automatic logic [W-1:0] elemVal(int seed, int i);
    return W'(seed * 40503 + i * i * 2654 + i * 97 + 12345);
  endfunction

  task automatic check(string req, longint actual, longint expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Send one stream of n elements: remainder strip first, then full strips.
  task automatic runStream(int n, int seed, bit holdBusy);
    logic [W-1:0] expected = '0;
    int idx = 0;
    int wait_c = 0;
    for (int i = 0; i < n; i++) expected = expected + elemVal(seed, i);
    do begin
      int cnt = (idx == 0 && (n % VL) != 0) ? (n % VL) : VL;
      if (n == 0) cnt = 0;
      @(negedge clk);
      inValid = 1'b1;
      inCount = ($clog2(VL)+1)'(cnt);
      inLast  = (idx + cnt >= n);
      for (int j = 0; j < VL; j++)
        inData[j*W +: W] = (j < cnt) ? elemVal(seed, idx + j) : W'(16'hBEEF + j); // R4 junk lanes
      idx += cnt;
    end while (idx < n);
    @(negedge clk);
    if (holdBusy) begin
      inLast = 1'b1;  // R9: keep offering junk while busy
      for (int j = 0; j < VL; j++) inData[j*W +: W] = W'(16'h7A5A ^ j);
      inCount = ($clog2(VL)+1)'(VL);
    end else begin
      inValid = 1'b0;
    end
    wait_c = 1;
    check("R2 ready low after last", inReady, 0);
    while (!outValid && wait_c < 20) begin
      @(negedge clk);
      wait_c++;
    end
    inValid = 1'b0;
    check("R5 result latency", wait_c, LEVELS + 1);
    check("R6 sum", outSum, expected);
    if (n == 0) check("R7 empty stream", outSum, 0);
    if (holdBusy) check("R9 busy input ignored", outSum, expected);
    @(negedge clk);
    check("R5 single pulse", outValid, 0);
    check("R8 ready again", inReady, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outValid after reset", outValid, 0);
    check("R1 inReady after reset", inReady, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle outValid", outValid, 0);

    // R3 R4 R6 table-driven streams, including N=0 (R7) and ragged lengths
    for (int c = 0; c < NCASE; c++) runStream(CASE_N[c], CASE_SEED[c], 1'b0);

    // R9: sender stays valid through the tree phase
    runStream(13, 41, 1'b1);
    // R8: following stream independent of the previous one
    runStream(5, 43, 1'b0);
    // R1 R7: empty stream right after a reset mid-way
    @(negedge clk);
    inValid = 1'b1; inCount = ($clog2(VL)+1)'(3); inLast = 1'b0;
    inData = {VL{W'(16'h1111)}};
    @(negedge clk);
    inValid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    runStream(0, 0, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule